// File: doc/BRIEF.md
# Configurable AND-OR logic array

This block is a combinational logic array whose function is set at run time. Eight dedicated inputs and ten bidirectional pins feed a plane of product terms. Each bidirectional pin is modelled as three signals: a pad input, a data output and an output enable. The pad inputs feed back into the plane, so every product term sees 18 signals. Each signal can be used in true form, in complement form, in both forms or not at all.

There are 42 product terms. Thirty-two of them are shared logic terms, and any subset of them can be summed into each of the ten outputs. A per-output polarity bit then inverts the sum or leaves it unchanged. The other ten terms are direction terms, one per pin, and each one drives that pin's output enable.

All programming bits sit in a configuration image that is shifted in serially. A load strobe copies the shifted image into the active configuration in a single cycle. A synchronous reset puts the active configuration into the unprogrammed state, in which every term is inhibited.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high at a clock edge, both the shift register and the active configuration take the unprogrammed image. In that image every AND link is kept, every term feeds every output and every polarity bit is 0. From then on `dout_o` and `oe_o` are all zero for any input, including after a load that follows with no shifting.
- R2: Each cycle with `cfg_shift_en` high shifts `cfg_sdi` into the image. The image has 1842 bits, and the stream position of each bit is fixed as follows. AND link (term t, signal s, form c) is at position t*36+2*s+c. OR link (term p, output o) is at position 1512+p*10+o. Polarity of output o is at position 1832+o. Here t is 0..41, with 32+n being the direction term of pin n, s is 0..17, with 0..7 = `in_i` and 8..17 = `pad_i[s-8]`, and c is 0 for the true form and 1 for the complement form.
- R3: The active configuration changes only on a cycle with `cfg_load` high, when it takes the shifted image. Shifting without a load leaves the outputs unchanged.
- R4: A product term is the AND of its kept literals. A signal whose two links are both removed does not affect the term.
- R5: A term that keeps both the true and the complement link of any signal is 0 for every input.
- R6: Output sum o is the OR of all logic terms whose OR link to o is kept. Any subset of the 32 terms, up to all of them, may be summed.
- R7: `dout_o[o]` is the sum XOR the polarity bit, where 1 inverts.
- R8: `oe_o[n]` equals direction term n.
- R9: `pad_i` values act as array signals 8..17 in both logic terms and direction terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset to the unprogrammed image |
| cfg_shift_en | input | 1 | Shift one image bit this cycle |
| cfg_sdi | input | 1 | Serial image bit, first bit first |
| cfg_load | input | 1 | Copy the shifted image into the active configuration |
| in_i | input | 8 | Dedicated array inputs |
| pad_i | input | 10 | Pad levels of the bidirectional pins |
| dout_o | output | 10 | Data to drive on each pin |
| oe_o | output | 10 | Output enable of each pin |

## Verification
The first directed case is a single term with one true and one complement literal, swept over input values. It separates kept literals from don't-care ones and confirms the link positions in the stream. A case where all 32 terms feed one output, with a single term removed and one output fed by a single term, tells a wide OR apart from a narrow one. Conflicting true and complement links show that a term is killed even when it is connected. Direction terms driven by pad values separate enable behaviour from data and exercise the feedback. Random images then run against a bench-side sum-of-products model, and shifting without a load checks that the active image is isolated.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Stream position of an AND link: term t, signal s, form c (0 true, 1 complement)
  function automatic int and_stream(int links, int t, int s, int c);
    return t * links + 2 * s + c;
  endfunction

  // Stream position of an OR link: logic term p to output o
  function automatic int or_stream(int and_bits, int n_pin, int p, int o);
    return and_bits + p * n_pin + o;
  endfunction

  // Stream position of the polarity bit of output o
  function automatic int pol_stream(int and_bits, int or_bits, int o);
    return and_bits + or_bits + o;
  endfunction

  // The first bit shifted in ends at the top of the image vector
  function automatic int stream_to_bit(int total, int k);
    return total - 1 - k;
  endfunction

  // One signal's contribution to a product term
  function automatic logic literal_ok(logic keep_true, logic keep_comp, logic x);
    return (~keep_true | x) & (~keep_comp | ~x);
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int TOTAL = 1842,
  parameter int N_POL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             load,
  output logic [TOTAL-1:0] cfg_o
);
  // Unprogrammed image: every link kept, polarity bits (last streamed) cleared
  localparam logic [TOTAL-1:0] RST_IMG = {{(TOTAL-N_POL){1'b1}}, {N_POL{1'b0}}};

  logic [TOTAL-1:0] shadow;
  logic [TOTAL-1:0] active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_IMG;
    end else if (shift_en) begin
      shadow <= {shadow[TOTAL-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= RST_IMG;
    end else if (load) begin
      active <= shadow;
    end
  end

  assign cfg_o = active;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(active)) else $error("cfg held"); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst) load |=> (active == $past(shadow))) else $error("cfg load"); // R3
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst) shift_en |=> (shadow[0] == $past(sdi))) else $error("shift in"); // R2
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst) !shift_en |=> $stable(shadow)) else $error("shift idle"); // R2

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_SIG = 18,
  parameter int N_PT  = 42,
  localparam int LINKS = 2 * N_SIG
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SIG-1:0]      sig_i,
  input  logic [N_PT*LINKS-1:0] links_i,   // term t link j at t*LINKS+j
  output logic [N_PT-1:0]       term_o
);
  logic [N_PT-1:0] conflict;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [LINKS-1:0] lk;
    assign lk = links_i[t*LINKS +: LINKS];

    always_comb begin
      term_o[t] = 1'b1;
      for (int s = 0; s < N_SIG; s++) begin
        term_o[t] = term_o[t] & pla_pkg::literal_ok(lk[2*s], lk[2*s+1], sig_i[s]);
      end
    end

    always_comb begin
      conflict[t] = 1'b0;
      for (int s = 0; s < N_SIG; s++) begin
        conflict[t] = conflict[t] | (lk[2*s] & lk[2*s+1]);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      for (int t = 0; t < N_PT; t++) begin
        AST_CONFLICT_KILLS: assert (!(conflict[t] && term_o[t])) else $error("conflicting term active"); // R5
      end
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 32,
  parameter int N_PIN  = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_TERM-1:0]         term_i,
  input  logic [N_TERM*N_PIN-1:0]   sel_i,    // term p to output o at p*N_PIN+o
  input  logic [N_PIN-1:0]          pol_i,
  output logic [N_PIN-1:0]          dout_o
);
  logic [N_PIN-1:0] hit;

  for (genvar o = 0; o < N_PIN; o++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar p = 0; p < N_TERM; p++) begin : g_col
      assign col[p] = sel_i[p*N_PIN + o];
    end
    assign hit[o]    = |(term_i & col);
    assign dout_o[o] = hit[o] ^ pol_i[o];
  end

  always @(posedge clk) begin
    if (!rst) begin
      for (int o = 0; o < N_PIN; o++) begin
        AST_IDLE_SUM_POLARITY: assert ((|(term_i & {N_TERM{1'b1}})) || (dout_o[o] == pol_i[o])) else $error("idle sum"); // R7
      end
    end
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 8,
  parameter int N_PIN  = 10,
  parameter int N_TERM = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_shift_en,
  input  logic              cfg_sdi,
  input  logic              cfg_load,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_PIN-1:0]  pad_i,
  output logic [N_PIN-1:0]  dout_o,
  output logic [N_PIN-1:0]  oe_o
);
  localparam int N_SIG    = N_IN + N_PIN;
  localparam int LINKS    = 2 * N_SIG;
  localparam int N_PT     = N_TERM + N_PIN;
  localparam int AND_BITS = N_PT * LINKS;
  localparam int OR_BITS  = N_TERM * N_PIN;
  localparam int TOTAL    = AND_BITS + OR_BITS + N_PIN;

  logic [TOTAL-1:0]        cfg;
  logic [N_PT*LINKS-1:0]   and_links;
  logic [OR_BITS-1:0]      or_sel;
  logic [N_PIN-1:0]        pol;
  logic [N_SIG-1:0]        sig;
  logic [N_PT-1:0]         terms;

  pla_cfg_chain #(.TOTAL(TOTAL), .N_POL(N_PIN)) u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_shift_en), .sdi(cfg_sdi),
    .load(cfg_load), .cfg_o(cfg)
  );

  // Route image bits to the planes by stream position
  for (genvar t = 0; t < N_PT; t++) begin : g_and_map
    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
      for (genvar c = 0; c < 2; c++) begin : g_form
        localparam int K = pla_pkg::and_stream(LINKS, t, s, c);
        assign and_links[t*LINKS + 2*s + c] = cfg[pla_pkg::stream_to_bit(TOTAL, K)];
      end
    end
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_or_map
    for (genvar o = 0; o < N_PIN; o++) begin : g_out
      localparam int K = pla_pkg::or_stream(AND_BITS, N_PIN, p, o);
      assign or_sel[p*N_PIN + o] = cfg[pla_pkg::stream_to_bit(TOTAL, K)];
    end
  end

  for (genvar o = 0; o < N_PIN; o++) begin : g_pol_map
    localparam int K = pla_pkg::pol_stream(AND_BITS, OR_BITS, o);
    assign pol[o] = cfg[pla_pkg::stream_to_bit(TOTAL, K)];
  end

  // Dedicated inputs are signals 0..N_IN-1, pad feedback follows
  assign sig = {pad_i, in_i};

  pla_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) u_and (
    .clk(clk), .rst(rst), .sig_i(sig), .links_i(and_links), .term_o(terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_PIN(N_PIN)) u_or (
    .clk(clk), .rst(rst), .term_i(terms[N_TERM-1:0]), .sel_i(or_sel),
    .pol_i(pol), .dout_o(dout_o)
  );

  assign oe_o = terms[N_PT-1:N_TERM];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> ((dout_o == '0) && (oe_o == '0))) else $error("reset image not quiet"); // R1

endmodule

// File: tb/pla_array_tb.sv
`timescale 1ns/100ps
module pla_array_tb;
  localparam int NI   = 8;
  localparam int NP   = 10;
  localparam int NT   = 32;
  localparam int NS   = NI + NP;
  localparam int LK   = 2 * NS;
  localparam int NPT  = NT + NP;
  localparam int ANDB = NPT * LK;
  localparam int ORB  = NT * NP;
  localparam int TOT  = ANDB + ORB + NP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_shift_en = 1'b0;
  logic cfg_sdi = 1'b0;
  logic cfg_load = 1'b0;
  logic [NI-1:0] in_i = '0;
  logic [NP-1:0] pad_i = '0;
  logic [NP-1:0] dout_o;
  logic [NP-1:0] oe_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic img [TOT];
  logic img_old [TOT];

  always #2.5 clk = ~clk;

  pla_array u_dut (
    .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_sdi(cfg_sdi),
    .cfg_load(cfg_load), .in_i(in_i), .pad_i(pad_i), .dout_o(dout_o), .oe_o(oe_o)
  );

  // Reference sum-of-products model read from a stream-ordered image
  task automatic model(input logic im [TOT], output logic [NP-1:0] ed, output logic [NP-1:0] eo);
    logic [NPT-1:0] pt;
    for (int t = 0; t < NPT; t++) begin
      pt[t] = 1'b1;
      for (int s = 0; s < NS; s++) begin
        logic x;
        x = (s < NI) ? in_i[s] : pad_i[s-NI];
        if (im[t*LK + 2*s] && !x) pt[t] = 1'b0;
        if (im[t*LK + 2*s + 1] && x) pt[t] = 1'b0;
      end
    end
    for (int o = 0; o < NP; o++) begin
      logic sum;
      sum = 1'b0;
      for (int p = 0; p < NT; p++) if (pt[p] && im[ANDB + p*NP + o]) sum = 1'b1;
      ed[o] = sum ^ im[ANDB + ORB + o];
      eo[o] = pt[NT + o];
    end
  endtask

  task automatic check_exp(input string tag, input logic [NP-1:0] ed, input logic [NP-1:0] eo);
    total++;
    if (dout_o !== ed || oe_o !== eo) begin
      bad++;
      $display("FAIL %s in=%h pad=%h dout=%h/%h oe=%h/%h (actual/expected)", tag, in_i, pad_i, dout_o, ed, oe_o, eo);
    end
  endtask

  task automatic drive(input logic [NI-1:0] a, input logic [NP-1:0] b);
    @(negedge clk);
    in_i = a;
    pad_i = b;
    #1;
  endtask

  task automatic check_model(input string tag);
    logic [NP-1:0] ed, eo;
    model(img, ed, eo);
    check_exp(tag, ed, eo);
  endtask

  // Image editing helpers
  task automatic blank();
    for (int k = 0; k < TOT; k++) img[k] = (k < ANDB);
  endtask
  task automatic free_term(input int t);
    for (int j = 0; j < LK; j++) img[t*LK + j] = 1'b0;
  endtask
  task automatic lit(input int t, input int s, input int c);
    img[t*LK + 2*s + c] = 1'b1;
  endtask
  task automatic conn(input int p, input int o, input logic v);
    img[ANDB + p*NP + o] = v;
  endtask
  task automatic setpol(input int o, input logic v);
    img[ANDB + ORB + o] = v;
  endtask

  task automatic shift_image();
    for (int k = 0; k < TOT; k++) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_sdi = img[k];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic program_image();
    shift_image();
    pulse_load();
    for (int k = 0; k < TOT; k++) img_old[k] = img[k];
  endtask

  task automatic test_reset();
    for (int i = 0; i < 6; i++) begin
      drive(NI'($urandom), NP'($urandom));
      check_exp("R1 reset image quiet", '0, '0);
    end
    @(negedge clk);
    pulse_load();
    drive(8'hff, 10'h3ff);
    check_exp("R1 load after reset stays unprogrammed", '0, '0);
  endtask

  task automatic test_single_term();
    blank();
    free_term(0);
    lit(0, 0, 0);   // in0 true
    lit(0, 3, 1);   // in3 complement
    conn(0, 2, 1'b1);
    program_image();
    for (int v = 0; v < 16; v++) begin
      logic [NP-1:0] ed;
      drive({4'($urandom), 4'(v)}, NP'($urandom));
      ed = '0;
      ed[2] = (v[0] == 1'b1) && (v[3] == 1'b0);
      check_exp("R4 single term literals and don't care", ed, '0);
    end
  endtask

  task automatic test_conflict();
    blank();
    free_term(2);
    lit(2, 0, 0);
    lit(2, NI + 3, 0);
    lit(2, NI + 3, 1);   // both forms of pad3 kept
    conn(2, 1, 1'b1);
    free_term(NT + 7);
    lit(NT + 7, 2, 0);
    lit(NT + 7, 2, 1);
    program_image();
    for (int i = 0; i < 8; i++) begin
      drive(NI'($urandom) | 8'h01, NP'($urandom));
      check_exp("R5 conflicting links kill the term", '0, '0);
    end
  endtask

  task automatic test_wide_or(input logic invert);
    blank();
    for (int t = 0; t < NT; t++) begin
      free_term(t);
      for (int b = 0; b < 5; b++) lit(t, b, ((t >> b) & 1) ? 0 : 1);
      conn(t, 9, 1'b1);
    end
    conn(17, 9, 1'b0);
    conn(31, 0, 1'b1);
    setpol(9, invert);
    setpol(3, invert);
    program_image();
    for (int v = 0; v < 32; v++) begin
      logic [NP-1:0] ed;
      drive({3'($urandom), 5'(v)}, NP'($urandom));
      ed = '0;
      ed[9] = (v != 17) ^ invert;
      ed[0] = (v == 31);
      ed[3] = invert;
      check_exp(invert ? "R7 polarity inverts the sum" : "R6 wide OR of shared terms", ed, '0);
    end
  endtask

  task automatic test_direction();
    blank();
    free_term(NT + 4);
    lit(NT + 4, NI + 1, 0);  // pad1 true
    lit(NT + 4, 7, 1);       // in7 complement
    free_term(0);
    lit(0, NI + 6, 1);       // pad6 complement
    conn(0, 5, 1'b1);
    program_image();
    for (int i = 0; i < 16; i++) begin
      logic [NI-1:0] a;
      logic [NP-1:0] b, ed, eo;
      a = NI'($urandom);
      b = NP'($urandom);
      drive(a, b);
      ed = '0; eo = '0;
      eo[4] = b[1] && !a[7];
      ed[5] = !b[6];
      check_exp("R8 R9 direction term and pad feedback", ed, eo);
    end
  endtask

  task automatic rand_image();
    for (int t = 0; t < NPT; t++) begin
      free_term(t);
      for (int s = 0; s < NS; s++) begin
        int r;
        r = int'($urandom % 24);
        if (r == 0) lit(t, s, 0);
        else if (r == 1) lit(t, s, 1);
        else if (r == 2 && (t % 7) == 0) begin lit(t, s, 0); lit(t, s, 1); end
      end
    end
    for (int p = 0; p < NT; p++)
      for (int o = 0; o < NP; o++) conn(p, o, ($urandom % 4) == 0);
    for (int o = 0; o < NP; o++) setpol(o, $urandom % 2);
  endtask

  task automatic test_shift_no_load();
    logic [NP-1:0] ed, eo;
    rand_image();
    shift_image();
    for (int i = 0; i < 10; i++) begin
      drive(NI'($urandom), NP'($urandom));
      model(img_old, ed, eo);
      check_exp("R3 shifting without load leaves outputs", ed, eo);
    end
    pulse_load();
    for (int k = 0; k < TOT; k++) img_old[k] = img[k];
    for (int i = 0; i < 10; i++) begin
      drive(NI'($urandom), NP'($urandom));
      check_model("R3 load applies new image");
    end
  endtask

  task automatic test_random();
    for (int n = 0; n < 3; n++) begin
      rand_image();
      program_image();
      for (int i = 0; i < 40; i++) begin
        drive(NI'($urandom), NP'($urandom));
        check_model("R2 R6 random image vs model");
      end
    end
  endtask

  task automatic test_midrun_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      drive(NI'($urandom), NP'($urandom));
      check_exp("R1 reset restores unprogrammed image", '0, '0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_single_term();
    test_conflict();
    test_wide_or(1'b0);
    test_wide_or(1'b1);
    test_direction();
    test_shift_no_load();
    test_random();
    test_midrun_reset();
    finish_run();
  end

endmodule